// File: doc/BRIEF.md
# Mailbox Interrupt Control and Status Register

This block is the 32-bit interrupt control and status word of a bus-bridge mailbox. The host reads it as one word and writes it with per-byte enables. The local side reports mailbox traffic on two sets of per-byte strobes: one set for writes into the incoming mailbox and one set for reads from the outgoing mailbox. The local side also drives an active-low add-on interrupt line.

For each mailbox direction, a 2-bit field selects one byte lane. An access on that lane sets a sticky flag, and the host clears the flag by writing a one to it. The add-on line passes through a two-flop synchronizer into a live status bit. Each of the three sources has its own enable. The block combines the enabled sources into an active-low host interrupt. It also forms a summary bit that always includes both mailbox flags, and includes the add-on source only when that source is enabled.

Mailbox data storage, bus timing and address decoding stay outside the block. The read data is always the current register value.

Top module: `mbx_irq_csr`

## Requirements
- R1: Bits 31:24, 21:18, 15:14 and 7:5 always read 0. Writing ones to them changes no readable bit.
- R2: Bits 11:10 and 3:2 always read 1.
- R3: Bit 13 (add-on enable), bit 12 (incoming enable), bits 9:8 (incoming byte select), bit 4 (outgoing enable) and bits 1:0 (outgoing byte select) are read/write. A host write updates a field only when the byte enable for the byte holding it is set (host_be[n] covers bits 8n+7:8n).
- R4: Bit 17 is set one cycle after a strobe on inb_wr_stb[k], where k is the value of bits 9:8 (00 selects byte 0, 01 byte 1, 10 byte 2, 11 byte 3). Strobes on other lanes leave it unchanged.
- R5: Bit 16 is set one cycle after a strobe on outb_rd_stb[k], where k is the value of bits 1:0, using the same encoding. Strobes on other lanes leave it unchanged.
- R6: A host write with host_be[2] set and data bit 17 (or bit 16) equal to 1 clears that flag. A write with data 0 in that bit leaves the flag unchanged.
- R7: When a set event and a write-one-to-clear hit the same flag in the same cycle, the flag ends up set.
- R8: Bit 22 reads 1 two clock edges after addon_irq_n goes low, and reads 0 two edges after it returns high, whatever the value of bit 13.
- R9: Bit 23 equals bit 17 OR bit 16 OR (bit 22 AND bit 13).
- R10: host_irq_n is 0 exactly when (bit 17 AND bit 12), (bit 16 AND bit 4) or (bit 22 AND bit 13) holds. Otherwise it is 1.
- R11: After reset the register reads 32'h00000C0C and host_irq_n is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| host_wr | input | 1 | Host write strobe |
| host_be | input | 4 | Host byte enables |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Current register value |
| inb_wr_stb | input | 4 | Per-byte local write strobes, incoming mailbox |
| outb_rd_stb | input | 4 | Per-byte local read strobes, outgoing mailbox |
| addon_irq_n | input | 1 | Active-low add-on interrupt request |
| host_irq_n | output | 1 | Active-low host interrupt |

## Verification
The bench walks every select encoding in both directions. It strobes all non-selected lanes first, so a design that decoded the select wrongly or ORed the lanes together would set a flag too early. It fires a local event and a host clear in the same cycle, which a design giving priority to the clear would lose. It drives the add-on line with the enable off, and checks that the status bit rises while the summary bit and the interrupt stay quiet. It also checks that the status bit takes exactly two edges to appear. Writes of ones to reserved bits, and writes with partial byte enables, expose a register that stores unused bits or ignores the lane enables.

// File: rtl/mbx_csr_pkg.sv
package mbx_csr_pkg;
  localparam int unsigned CSR_W        = 32;
  localparam int unsigned BIT_SUMMARY  = 23;
  localparam int unsigned BIT_ADDON    = 22;
  localparam int unsigned BIT_INB      = 17;
  localparam int unsigned BIT_OUTB     = 16;
  localparam int unsigned BIT_ADDON_EN = 13;
  localparam int unsigned BIT_INB_EN   = 12;
  localparam int unsigned INB_SEL_LO   = 8;
  localparam int unsigned BIT_OUTB_EN  = 4;
  localparam int unsigned OUTB_SEL_LO  = 0;
  localparam logic [CSR_W-1:0] ONES_MASK = 32'h0000_0C0C;
  localparam logic [CSR_W-1:0] RSVD_MASK = 32'hFF3C_C0E0;

  typedef enum logic {DIR_INB = 1'b0, DIR_OUTB = 1'b1} mbx_dir_e;
endpackage

// File: rtl/mbx_sync.sv
module mbx_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] shf_q;
  logic [STAGES-1:0] shf_d;

  always_comb begin
    shf_d = {shf_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shf_q <= {STAGES{RST_VAL}};
    else        shf_q <= shf_d;
  end

  assign q = shf_q[STAGES-1];
endmodule

// File: rtl/mbx_evt_latch.sv
module mbx_evt_latch #(
  parameter int NBYTES = 4,
  parameter int SELW   = $clog2(NBYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NBYTES-1:0] stb,
  input  logic [SELW-1:0]   sel,
  input  logic              clr,
  output logic              flag
);
  logic flag_q;
  logic flag_d;
  logic hit;

  always_comb begin
    hit    = stb[sel];
    // a local event outranks a host clear in the same cycle
    flag_d = hit | (flag_q & ~clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag = flag_q;
endmodule

// File: rtl/mbx_irq_csr.sv
module mbx_irq_csr
  import mbx_csr_pkg::*;
#(
  parameter int NBYTES      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic [3:0]        host_be,
  input  logic [CSR_W-1:0]  host_wdata,
  output logic [CSR_W-1:0]  host_rdata,
  input  logic [NBYTES-1:0] inb_wr_stb,
  input  logic [NBYTES-1:0] outb_rd_stb,
  input  logic              addon_irq_n,
  output logic              host_irq_n
);
  localparam int SELW  = $clog2(NBYTES);
  localparam int NDIR  = 2;

  logic rst_core_n;
  logic addon_n_s;

  mbx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_core_n)
  );

  mbx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_addon_sync (
    .clk(clk), .rst_n(rst_core_n), .d(addon_irq_n), .q(addon_n_s)
  );

  // control fields
  logic            addon_en_q, addon_en_d;
  logic            inb_en_q,   inb_en_d;
  logic            outb_en_q,  outb_en_d;
  logic [SELW-1:0] inb_sel_q,  inb_sel_d;
  logic [SELW-1:0] outb_sel_q, outb_sel_d;
  logic            wr_b0, wr_b1, wr_b2;

  always_comb begin
    wr_b0      = host_wr & host_be[0];
    wr_b1      = host_wr & host_be[1];
    wr_b2      = host_wr & host_be[2];
    addon_en_d = addon_en_q;
    inb_en_d   = inb_en_q;
    inb_sel_d  = inb_sel_q;
    outb_en_d  = outb_en_q;
    outb_sel_d = outb_sel_q;
    if (wr_b1) begin
      addon_en_d = host_wdata[BIT_ADDON_EN];
      inb_en_d   = host_wdata[BIT_INB_EN];
      inb_sel_d  = host_wdata[INB_SEL_LO +: SELW];
    end
    if (wr_b0) begin
      outb_en_d  = host_wdata[BIT_OUTB_EN];
      outb_sel_d = host_wdata[OUTB_SEL_LO +: SELW];
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      addon_en_q <= 1'b0;
      inb_en_q   <= 1'b0;
      inb_sel_q  <= '0;
      outb_en_q  <= 1'b0;
      outb_sel_q <= '0;
    end else begin
      addon_en_q <= addon_en_d;
      inb_en_q   <= inb_en_d;
      inb_sel_q  <= inb_sel_d;
      outb_en_q  <= outb_en_d;
      outb_sel_q <= outb_sel_d;
    end
  end

  // one sticky flag per mailbox direction
  logic [NBYTES-1:0] dir_stb [NDIR];
  logic [SELW-1:0]   dir_sel [NDIR];
  logic              dir_clr [NDIR];
  logic              dir_flag[NDIR];

  always_comb begin
    dir_stb[DIR_INB]  = inb_wr_stb;
    dir_sel[DIR_INB]  = inb_sel_q;
    dir_clr[DIR_INB]  = wr_b2 & host_wdata[BIT_INB];
    dir_stb[DIR_OUTB] = outb_rd_stb;
    dir_sel[DIR_OUTB] = outb_sel_q;
    dir_clr[DIR_OUTB] = wr_b2 & host_wdata[BIT_OUTB];
  end

  for (genvar g = 0; g < NDIR; g++) begin : g_dir
    mbx_evt_latch #(.NBYTES(NBYTES), .SELW(SELW)) u_latch (
      .clk(clk), .rst_n(rst_core_n), .stb(dir_stb[g]), .sel(dir_sel[g]),
      .clr(dir_clr[g]), .flag(dir_flag[g])
    );
  end

  logic addon_stat;
  logic summary;
  logic irq_any;

  always_comb begin
    addon_stat = ~addon_n_s;
    summary    = dir_flag[DIR_INB] | dir_flag[DIR_OUTB] | (addon_stat & addon_en_q);
    irq_any    = (dir_flag[DIR_INB] & inb_en_q) | (dir_flag[DIR_OUTB] & outb_en_q)
               | (addon_stat & addon_en_q);
  end

  always_comb begin
    host_rdata                              = ONES_MASK;
    host_rdata[BIT_SUMMARY]                 = summary;
    host_rdata[BIT_ADDON]                   = addon_stat;
    host_rdata[BIT_INB]                     = dir_flag[DIR_INB];
    host_rdata[BIT_OUTB]                    = dir_flag[DIR_OUTB];
    host_rdata[BIT_ADDON_EN]                = addon_en_q;
    host_rdata[BIT_INB_EN]                  = inb_en_q;
    host_rdata[INB_SEL_LO +: SELW]          = inb_sel_q;
    host_rdata[BIT_OUTB_EN]                 = outb_en_q;
    host_rdata[OUTB_SEL_LO +: SELW]         = outb_sel_q;
    host_irq_n                              = ~irq_any;
  end
endmodule

// File: rtl/mbx_irq_csr_chk.sv
module mbx_irq_csr_chk
  import mbx_csr_pkg::*;
#(
  parameter int NBYTES = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_wr,
  input logic [3:0]        host_be,
  input logic [CSR_W-1:0]  host_wdata,
  input logic [CSR_W-1:0]  host_rdata,
  input logic [NBYTES-1:0] inb_wr_stb,
  input logic [NBYTES-1:0] outb_rd_stb,
  input logic              addon_irq_n,
  input logic              host_irq_n
);
  logic [2:0] cyc_q;
  logic       live;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cyc_q <= '0;
    else if (cyc_q != 3'd7) cyc_q <= cyc_q + 3'd1;
  end

  assign live = (cyc_q >= 3'd5);

  assert_rsvd_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rdata & RSVD_MASK) == '0);

  assert_ones_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rdata & ONES_MASK) == ONES_MASK);

  assert_inb_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (live && inb_wr_stb[host_rdata[9:8]]) |=> host_rdata[17]);

  assert_outb_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (live && outb_rd_stb[host_rdata[1:0]]) |=> host_rdata[16]);

  assert_inb_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (live && host_wr && host_be[2] && host_wdata[17] && !inb_wr_stb[host_rdata[9:8]])
    |=> !host_rdata[17]);

  assert_addon_sync_R8: assert property (@(posedge clk) disable iff (!rst_n)
    live |-> (host_rdata[22] == !$past(addon_irq_n, 2)));

  assert_summary_R9: assert property (@(posedge clk) disable iff (!rst_n)
    host_rdata[23] == (host_rdata[17] | host_rdata[16] | (host_rdata[22] & host_rdata[13])));

  assert_irq_R10: assert property (@(posedge clk) disable iff (!rst_n)
    host_irq_n == !((host_rdata[17] & host_rdata[12]) | (host_rdata[16] & host_rdata[4])
                    | (host_rdata[22] & host_rdata[13])));
endmodule

bind mbx_irq_csr mbx_irq_csr_chk #(.NBYTES(NBYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_be(host_be),
  .host_wdata(host_wdata), .host_rdata(host_rdata), .inb_wr_stb(inb_wr_stb),
  .outb_rd_stb(outb_rd_stb), .addon_irq_n(addon_irq_n), .host_irq_n(host_irq_n)
);

// File: tb/mbx_irq_csr_tb.sv
module mbx_irq_csr_tb;
  logic        clk;
  logic        rst_n;
  logic        host_wr;
  logic [3:0]  host_be;
  logic [31:0] host_wdata;
  logic [31:0] host_rdata;
  logic [3:0]  inb_wr_stb;
  logic [3:0]  outb_rd_stb;
  logic        addon_irq_n;
  logic        host_irq_n;

  int checks;
  int errors;

  mbx_irq_csr u_dut (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_be(host_be),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .inb_wr_stb(inb_wr_stb),
    .outb_rd_stb(outb_rd_stb), .addon_irq_n(addon_irq_n), .host_irq_n(host_irq_n)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // drive at a falling edge, hold across one rising edge
  task automatic hwrite(input logic [31:0] d, input logic [3:0] be);
    host_wr = 1'b1; host_be = be; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0; host_be = '0; host_wdata = '0;
  endtask

  task automatic pulse(input logic [3:0] inb, input logic [3:0] outb);
    inb_wr_stb = inb; outb_rd_stb = outb;
    @(negedge clk);
    inb_wr_stb = '0; outb_rd_stb = '0;
  endtask

  task automatic t_reset();
    check("R11 reset value", host_rdata, 32'h0000_0C0C);
    check("R11 reset irq", {31'd0, host_irq_n}, 32'd1);
  endtask

  task automatic t_reserved();
    hwrite(32'hFFFF_FFFF, 4'hF);
    check("R1 R2 R3 all-ones write", host_rdata, 32'h0000_3F1F);
    check("R10 no source no irq", {31'd0, host_irq_n}, 32'd1);
  endtask

  task automatic t_byte_en();
    hwrite(32'h0000_0000, 4'b0001);
    check("R3 byte0 only", host_rdata, 32'h0000_3F0C);
    hwrite(32'h0000_0000, 4'b0010);
    check("R3 byte1 only", host_rdata, 32'h0000_0C0C);
    hwrite(32'h0000_3F1F, 4'b1100);
    check("R3 upper lanes leave controls", host_rdata, 32'h0000_0C0C);
  endtask

  task automatic t_inbound();
    for (int s = 0; s < 4; s++) begin
      hwrite((32'h10 | s) << 8, 4'b0010);
      pulse(4'hF & ~(4'h1 << s), 4'h0);
      check($sformatf("R4 other lanes sel=%0d", s), {31'd0, host_rdata[17]}, 32'd0);
      pulse(4'h1 << s, 4'h0);
      check($sformatf("R4 selected lane sel=%0d", s), {31'd0, host_rdata[17]}, 32'd1);
      check("R10 inbound irq", {31'd0, host_irq_n}, 32'd0);
      check("R9 summary inbound", {31'd0, host_rdata[23]}, 32'd1);
      hwrite(32'h0000_0000, 4'b0100);
      check("R6 write zero keeps", {31'd0, host_rdata[17]}, 32'd1);
      hwrite(32'h0002_0000, 4'b0100);
      check("R6 write one clears", {31'd0, host_rdata[17]}, 32'd0);
      check("R10 irq released", {31'd0, host_irq_n}, 32'd1);
    end
  endtask

  task automatic t_outbound();
    for (int s = 0; s < 4; s++) begin
      hwrite(32'h10 | s, 4'b0001);
      pulse(4'h0, 4'hF & ~(4'h1 << s));
      check($sformatf("R5 other lanes sel=%0d", s), {31'd0, host_rdata[16]}, 32'd0);
      pulse(4'h0, 4'h1 << s);
      check($sformatf("R5 selected lane sel=%0d", s), {31'd0, host_rdata[16]}, 32'd1);
      check("R10 outbound irq", {31'd0, host_irq_n}, 32'd0);
      hwrite(32'h0001_0000, 4'b0100);
      check("R6 outbound clear", {31'd0, host_rdata[16]}, 32'd0);
    end
    hwrite(32'h0, 4'b0001);
  endtask

  task automatic t_enable_off();
    hwrite(32'h0000_0100, 4'b0010);
    pulse(4'b0010, 4'h0);
    check("R4 flag with enable off", {31'd0, host_rdata[17]}, 32'd1);
    check("R9 summary ignores enable", {31'd0, host_rdata[23]}, 32'd1);
    check("R10 masked source", {31'd0, host_irq_n}, 32'd1);
    hwrite(32'h0002_0000, 4'b0100);
  endtask

  task automatic t_set_wins();
    host_wr = 1'b1; host_be = 4'b0100; host_wdata = 32'h0002_0000;
    inb_wr_stb = 4'b0010;
    @(negedge clk);
    host_wr = 1'b0; host_be = '0; host_wdata = '0; inb_wr_stb = '0;
    check("R7 set beats clear", {31'd0, host_rdata[17]}, 32'd1);
    hwrite(32'h0002_0000, 4'b0100);
    check("R6 clear after race", {31'd0, host_rdata[17]}, 32'd0);
    hwrite(32'h0, 4'b0010);
  endtask

  task automatic t_addon();
    addon_irq_n = 1'b0;
    @(negedge clk);
    check("R8 one edge not yet", {31'd0, host_rdata[22]}, 32'd0);
    @(negedge clk);
    check("R8 pin low seen", {31'd0, host_rdata[22]}, 32'd1);
    check("R9 summary masked addon", {31'd0, host_rdata[23]}, 32'd0);
    check("R10 masked addon", {31'd0, host_irq_n}, 32'd1);
    hwrite(32'h0000_2000, 4'b0010);
    check("R9 summary addon enabled", {31'd0, host_rdata[23]}, 32'd1);
    check("R10 addon irq", {31'd0, host_irq_n}, 32'd0);
    addon_irq_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R8 pin high seen", {31'd0, host_rdata[22]}, 32'd0);
    check("R10 addon released", {31'd0, host_irq_n}, 32'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    checks = 0; errors = 0;
    rst_n = 1'b0; host_wr = 1'b0; host_be = '0; host_wdata = '0;
    inb_wr_stb = '0; outb_rd_stb = '0; addon_irq_n = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_reserved();
    t_byte_en();
    t_inbound();
    t_outbound();
    t_enable_off();
    t_set_wins();
    t_addon();
    finish_run();
  end
endmodule